// File: doc/BRIEF.md
# Alert-Tag Transaction Abort Monitor

This block keeps, for a single core, a small set of cache-line addresses that the running transaction has asked to be warned about. When any line in that set leaves the local cache, whether a remote core takes it for writing or the cache evicts it for space, the monitor raises an abort request. The request carries the program counter of a software handler registered earlier, so execution is redirected to software. Software then no longer needs to validate its read set, because losing a watched line is reported as soon as it happens. Transaction descriptors are watched the same way, so a remote core that writes a descriptor aborts its owner at once.

A transaction starts with the first tag request. It ends in one of two ways. A successful commit drops every tag quietly and returns the monitor to idle. An abort holds the request until the pipeline acknowledges it, and the monitor then drops every tag and goes idle. If the tag set is full and another distinct line is tagged, this counts as a capacity loss. If no handler has been registered when an abort fires, the monitor reports an error cause instead of a target address.

Top module: `alert_monitor`

## Requirements
- R1: After a tag request (`aload_i`) for a line, an invalidation of that line with `inval_capacity_i`=0 sets `abort_req_o` on the next clock edge. At that point `abort_pc_o` equals the registered handler and `abort_cause_o`=1 (coherence).
- R2: An invalidation of a tagged line with `inval_capacity_i`=1 raises an abort with `abort_cause_o`=2 (capacity).
- R3: An invalidation of an address that holds no tag does not raise an abort.
- R4: A release request (`arelease_i`) removes the tag for its line. A later invalidation of that line does not abort, while other tagged lines still abort.
- R5: A tag request for a line that is already tagged takes no extra entry. With NUM_TAGS lines tagged, repeating one of them raises no abort.
- R6: With all NUM_TAGS entries (default 8) in use, a tag request for a new line raises an abort with cause 2 (capacity).
- R7: A self-abort (`self_abort_i`) during an open transaction raises an abort with cause 3 and the handler PC.
- R8: A successful commit (`commit_ok_i`) drops every tag and raises no abort. After it, invalidating a formerly tagged line and issuing a self-abort both have no effect until the next tag request.
- R9: `abort_req_o` stays high with a stable PC and cause until `abort_ack_i`, and falls on the edge after the acknowledge. All tags are then dropped, so a later invalidation of a formerly tagged line does not abort.
- R10: An abort that fires before any handler has been registered reports cause 4 (no handler) with `abort_pc_o`=0.
- R11: When events coincide, the priority from highest to lowest is: an invalidation hitting a tag, then tag-set overflow, then self-abort, then commit.
- R12: After reset `abort_req_o`=0, `abort_cause_o`=0 and `abort_pc_o`=0, and these values hold whenever no abort is pending. An abort uses the most recently registered handler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| aload_i | input | 1 | Tag request for line_addr_i |
| arelease_i | input | 1 | Release request for line_addr_i |
| line_addr_i | input | ADDR_W | Line address of tag/release request |
| set_handler_i | input | 1 | Register handler_pc_i as abort target |
| handler_pc_i | input | PC_W | Handler address |
| inval_i | input | 1 | A line leaves the local cache |
| inval_capacity_i | input | 1 | 1 = eviction, 0 = coherence invalidation |
| inval_addr_i | input | ADDR_W | Address of the departing line |
| commit_ok_i | input | 1 | Commit succeeded |
| self_abort_i | input | 1 | Explicit abort instruction |
| abort_ack_i | input | 1 | Pipeline accepted the redirect |
| abort_req_o | output | 1 | Abort request, held until acknowledged |
| abort_pc_o | output | PC_W | Redirect target |
| abort_cause_o | output | 3 | 0 none, 1 coherence, 2 capacity, 3 self, 4 no handler |

## Verification
The bench releases one tag and then invalidates it. A store that ignored the release would abort here. It repeats a tag request on a full set, where a store that allocated duplicates would report a false capacity abort, and then overflows the set with a new line, where a store that wrapped around would stay silent. It also checks that the monitor stays quiet after a commit or an acknowledge. A monitor that kept stale tags, or that still honoured a self-abort while idle, would redirect again here. Finally, the bench fires coinciding events and an abort with no handler registered, where a wrong priority or an unset target would show up as the wrong cause or a nonzero PC.

// File: rtl/alert_mon_pkg.sv
package alert_mon_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE       = 3'd0,
    CAUSE_COHERENCE  = 3'd1,
    CAUSE_CAPACITY   = 3'd2,
    CAUSE_SELF       = 3'd3,
    CAUSE_NO_HANDLER = 3'd4
  } abort_cause_e;

  typedef enum logic [1:0] {
    MON_IDLE,
    MON_ACTIVE,
    MON_ABORT
  } mon_state_e;
endpackage

// File: rtl/alert_tag_store.sv
module alert_tag_store #(
  parameter int NUM_TAGS = 8,
  parameter int ADDR_W   = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              clear_i,
  input  logic              alloc_i,
  input  logic              release_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] probe_addr_i,
  output logic              probe_hit_o,
  output logic              full_miss_o
);
  localparam int IDX_W = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1;

  logic [NUM_TAGS-1:0]    valid_q;
  logic [ADDR_W-1:0]      addr_q [NUM_TAGS];
  logic [NUM_TAGS-1:0]    req_match, probe_match;
  logic [IDX_W-1:0]       free_idx;
  logic                   any_free;

  for (genvar g = 0; g < NUM_TAGS; g++) begin : g_cmp
    assign req_match[g]   = valid_q[g] && (addr_q[g] == addr_i);
    assign probe_match[g] = valid_q[g] && (addr_q[g] == probe_addr_i);
  end

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = NUM_TAGS - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign probe_hit_o = |probe_match;
  assign full_miss_o = alloc_i && !(|req_match) && !any_free;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < NUM_TAGS; i++) addr_q[i] <= '0;
    end else if (clear_i) begin
      valid_q <= '0;
    end else if (we_i) begin
      // tag request wins over a release in the same cycle
      if (alloc_i) begin
        if (!(|req_match) && any_free) begin
          valid_q[free_idx] <= 1'b1;
          addr_q[free_idx]  <= addr_i;
        end
      end else if (release_i) begin
        valid_q <= valid_q & ~req_match;
      end
    end
  end
endmodule

// File: rtl/alert_handler_reg.sv
module alert_handler_reg #(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  logic [PC_W-1:0] pc_i,
  output logic            valid_o,
  output logic [PC_W-1:0] pc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pc_o    <= '0;
    end else if (set_i) begin
      valid_o <= 1'b1;
      pc_o    <= pc_i;
    end
  end
endmodule

// File: rtl/alert_abort_ctrl.sv
module alert_abort_ctrl
  import alert_mon_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            aload_i,
  input  logic            inval_i,
  input  logic            inval_capacity_i,
  input  logic            commit_ok_i,
  input  logic            self_abort_i,
  input  logic            abort_ack_i,
  input  logic            probe_hit_i,
  input  logic            full_miss_i,
  input  logic            handler_valid_i,
  input  logic [PC_W-1:0] handler_pc_i,
  output logic            tag_we_o,
  output logic            tag_clear_o,
  output logic            abort_req_o,
  output logic [PC_W-1:0] abort_pc_o,
  output logic [2:0]      abort_cause_o
);
  mon_state_e   state_q, state_d;
  abort_cause_e cause_q, cause_d, trig_cause;
  logic [PC_W-1:0] pc_q, pc_d;
  logic         trig;

  always_comb begin
    trig       = 1'b1;
    trig_cause = CAUSE_NONE;
    if (inval_i && probe_hit_i)
      trig_cause = inval_capacity_i ? CAUSE_CAPACITY : CAUSE_COHERENCE;
    else if (full_miss_i)
      trig_cause = CAUSE_CAPACITY;
    else if (self_abort_i && state_q == MON_ACTIVE)
      trig_cause = CAUSE_SELF;
    else
      trig = 1'b0;
  end

  always_comb begin
    state_d     = state_q;
    cause_d     = cause_q;
    pc_d        = pc_q;
    tag_clear_o = 1'b0;
    unique case (state_q)
      MON_ABORT: begin
        if (abort_ack_i) begin
          state_d     = MON_IDLE;
          cause_d     = CAUSE_NONE;
          pc_d        = '0;
          tag_clear_o = 1'b1;
        end
      end
      default: begin
        if (trig) begin
          state_d = MON_ABORT;
          cause_d = handler_valid_i ? trig_cause : CAUSE_NO_HANDLER;
          pc_d    = handler_valid_i ? handler_pc_i : '0;
        end else if (commit_ok_i && state_q == MON_ACTIVE) begin
          state_d     = MON_IDLE;
          tag_clear_o = 1'b1;
        end else if (aload_i) begin
          state_d = MON_ACTIVE;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MON_IDLE;
      cause_q <= CAUSE_NONE;
      pc_q    <= '0;
    end else begin
      state_q <= state_d;
      cause_q <= cause_d;
      pc_q    <= pc_d;
    end
  end

  assign tag_we_o      = (state_q != MON_ABORT);
  assign abort_req_o   = (state_q == MON_ABORT);
  assign abort_pc_o    = pc_q;
  assign abort_cause_o = cause_q;
endmodule

// File: rtl/alert_monitor.sv
module alert_monitor #(
  parameter int NUM_TAGS = 8,
  parameter int ADDR_W   = 26,
  parameter int PC_W     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              aload_i,
  input  logic              arelease_i,
  input  logic [ADDR_W-1:0] line_addr_i,
  input  logic              set_handler_i,
  input  logic [PC_W-1:0]   handler_pc_i,
  input  logic              inval_i,
  input  logic              inval_capacity_i,
  input  logic [ADDR_W-1:0] inval_addr_i,
  input  logic              commit_ok_i,
  input  logic              self_abort_i,
  input  logic              abort_ack_i,
  output logic              abort_req_o,
  output logic [PC_W-1:0]   abort_pc_o,
  output logic [2:0]        abort_cause_o
);
  logic            tag_we, tag_clear, probe_hit, full_miss, hdl_valid;
  logic [PC_W-1:0] hdl_pc;

  alert_tag_store #(.NUM_TAGS(NUM_TAGS), .ADDR_W(ADDR_W)) u_tags (
    .clk_i, .rst_ni,
    .we_i        (tag_we),
    .clear_i     (tag_clear),
    .alloc_i     (aload_i),
    .release_i   (arelease_i),
    .addr_i      (line_addr_i),
    .probe_addr_i(inval_addr_i),
    .probe_hit_o (probe_hit),
    .full_miss_o (full_miss)
  );

  alert_handler_reg #(.PC_W(PC_W)) u_hdl (
    .clk_i, .rst_ni,
    .set_i  (set_handler_i),
    .pc_i   (handler_pc_i),
    .valid_o(hdl_valid),
    .pc_o   (hdl_pc)
  );

  alert_abort_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk_i, .rst_ni,
    .aload_i, .inval_i, .inval_capacity_i, .commit_ok_i, .self_abort_i, .abort_ack_i,
    .probe_hit_i    (probe_hit),
    .full_miss_i    (full_miss),
    .handler_valid_i(hdl_valid),
    .handler_pc_i   (hdl_pc),
    .tag_we_o       (tag_we),
    .tag_clear_o    (tag_clear),
    .abort_req_o, .abort_pc_o, .abort_cause_o
  );
endmodule

// File: rtl/alert_monitor_checker.sv
module alert_monitor_checker #(
  parameter int ADDR_W = 26,
  parameter int PC_W   = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              aload_i,
  input logic              inval_i,
  input logic              commit_ok_i,
  input logic              self_abort_i,
  input logic              abort_ack_i,
  input logic              abort_req_o,
  input logic [PC_W-1:0]   abort_pc_o,
  input logic [2:0]        abort_cause_o
);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_req_o && !abort_ack_i |=> abort_req_o && $stable(abort_pc_o) && $stable(abort_cause_o));

  p_ack_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_req_o && abort_ack_i |=> !abort_req_o);

  p_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !abort_req_o |-> (abort_cause_o == 3'd0) && (abort_pc_o == '0));

  p_no_handler_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_req_o && (abort_cause_o == 3'd4) |-> abort_pc_o == '0);

  p_commit_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !abort_req_o && commit_ok_i && !inval_i && !aload_i && !self_abort_i |=> !abort_req_o);

  p_has_trigger_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_req_o) |-> $past(inval_i || aload_i || self_abort_i) && (abort_cause_o != 3'd0));
endmodule

bind alert_monitor alert_monitor_checker #(.ADDR_W(ADDR_W), .PC_W(PC_W)) u_chk (.*);

// File: tb/alert_monitor_bench.sv
module alert_monitor_bench;
  localparam int ADDR_W = 26;
  localparam int PC_W   = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic aload_i = 0, arelease_i = 0, set_handler_i = 0, inval_i = 0, inval_capacity_i = 0;
  logic commit_ok_i = 0, self_abort_i = 0, abort_ack_i = 0;
  logic [ADDR_W-1:0] line_addr_i = '0, inval_addr_i = '0;
  logic [PC_W-1:0]   handler_pc_i = '0;
  logic              abort_req_o;
  logic [PC_W-1:0]   abort_pc_o;
  logic [2:0]        abort_cause_o;

  int n_run = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  alert_monitor u_alert_monitor (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // apply current inputs for one edge, then clear them
  task automatic tick();
    @(negedge clk_i);
    aload_i = 0; arelease_i = 0; set_handler_i = 0; inval_i = 0;
    inval_capacity_i = 0; commit_ok_i = 0; self_abort_i = 0; abort_ack_i = 0;
  endtask

  task automatic do_aload(input logic [ADDR_W-1:0] a);
    aload_i = 1; line_addr_i = a; tick();
  endtask
  task automatic do_release(input logic [ADDR_W-1:0] a);
    arelease_i = 1; line_addr_i = a; tick();
  endtask
  task automatic do_inval(input logic [ADDR_W-1:0] a, input logic cap);
    inval_i = 1; inval_addr_i = a; inval_capacity_i = cap; tick();
  endtask
  task automatic do_handler(input logic [PC_W-1:0] pc);
    set_handler_i = 1; handler_pc_i = pc; tick();
  endtask
  task automatic do_ack(input string req);
    abort_ack_i = 1; tick();
    chk(req, 32'(abort_req_o), 0);
    chk(req, 32'(abort_cause_o), 0);
  endtask

  task automatic t_reset();
    chk("R12 reset req", 32'(abort_req_o), 0);
    chk("R12 reset cause", 32'(abort_cause_o), 0);
    chk("R12 reset pc", abort_pc_o, 0);
  endtask

  task automatic t_no_handler();
    do_aload(26'h11);
    self_abort_i = 1; tick();
    chk("R10 req", 32'(abort_req_o), 1);
    chk("R10 cause", 32'(abort_cause_o), 4);
    chk("R10 pc", abort_pc_o, 0);
    do_ack("R10 ack");
  endtask

  task automatic t_coherence();
    do_handler(32'h1000);
    do_aload(26'h40);
    do_inval(26'h80, 1'b0);
    chk("R3 untagged", 32'(abort_req_o), 0);
    do_inval(26'h40, 1'b0);
    chk("R1 req", 32'(abort_req_o), 1);
    chk("R1 cause", 32'(abort_cause_o), 1);
    chk("R1 pc", abort_pc_o, 32'h1000);
    tick(); tick();
    chk("R9 held req", 32'(abort_req_o), 1);
    chk("R9 held pc", abort_pc_o, 32'h1000);
    do_ack("R9 ack");
    do_inval(26'h40, 1'b0);
    chk("R9 tags cleared", 32'(abort_req_o), 0);
  endtask

  task automatic t_evict();
    do_aload(26'h44);
    do_inval(26'h44, 1'b1);
    chk("R2 req", 32'(abort_req_o), 1);
    chk("R2 cause", 32'(abort_cause_o), 2);
    do_ack("R2 ack");
  endtask

  task automatic t_release();
    do_aload(26'h10);
    do_aload(26'h20);
    do_release(26'h10);
    do_inval(26'h10, 1'b0);
    chk("R4 released", 32'(abort_req_o), 0);
    do_inval(26'h20, 1'b0);
    chk("R4 kept", 32'(abort_cause_o), 1);
    do_ack("R4 ack");
  endtask

  task automatic t_full();
    do_handler(32'h2000);
    for (int i = 0; i < 8; i++) do_aload(26'(32'h100 + i));
    chk("R6 eight fit", 32'(abort_req_o), 0);
    do_aload(26'h103);
    chk("R5 repeat", 32'(abort_req_o), 0);
    do_aload(26'h1ff);
    chk("R6 overflow req", 32'(abort_req_o), 1);
    chk("R6 overflow cause", 32'(abort_cause_o), 2);
    chk("R12 new handler", abort_pc_o, 32'h2000);
    do_ack("R6 ack");
  endtask

  task automatic t_commit();
    do_aload(26'h30);
    commit_ok_i = 1; tick();
    chk("R8 commit", 32'(abort_req_o), 0);
    do_inval(26'h30, 1'b0);
    chk("R8 after commit", 32'(abort_req_o), 0);
    self_abort_i = 1; tick();
    chk("R8 idle self", 32'(abort_req_o), 0);
  endtask

  task automatic t_self();
    do_aload(26'h30);
    self_abort_i = 1; tick();
    chk("R7 cause", 32'(abort_cause_o), 3);
    chk("R7 pc", abort_pc_o, 32'h2000);
    do_ack("R7 ack");
  endtask

  task automatic t_priority();
    do_aload(26'h50);
    inval_i = 1; inval_addr_i = 26'h50; self_abort_i = 1; commit_ok_i = 1; tick();
    chk("R11 inval first", 32'(abort_cause_o), 1);
    do_ack("R11 ack");
    do_aload(26'h51);
    self_abort_i = 1; commit_ok_i = 1; tick();
    chk("R11 self over commit", 32'(abort_cause_o), 3);
    do_ack("R11 ack2");
  endtask

  initial begin
    #(200000 * 10);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_no_handler();
    t_coherence();
    t_evict();
    t_release();
    t_full();
    t_commit();
    t_self();
    t_priority();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule